// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescing

This block holds the control and status registers for the two channels of a descriptor-based DMA engine, together with the logic that decides when each channel raises its interrupt. Software reaches the registers over a simple read/write bus. The byte address is split into 0x30-byte windows, and the low bit of the window number selects the channel. The engine that fetches descriptors and moves data lives elsewhere. It sees this block through a run level, the descriptor pointers, and a one-cycle strobe that follows each write of the tail pointer. In the other direction it reports completions, reaching the tail and halting, each as a single-cycle pulse.

Interrupts are coalesced in two ways. A completion counter counts down from a programmed threshold and flags a completion interrupt each time it reaches zero. A delay timer is armed again by every completion and flags a delay interrupt if it runs out before another completion arrives. The timer counts a shared prescaled tick and not the clock. A status read shows the live counter and timer values, so software can see how far each channel is from its next interrupt.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, each channel's status reads 0x0001_0001 (halted set, counter 1) and its control reads 0x0001_0002 (threshold 1, bit 1 set). All interrupt outputs and run outputs are low and both halted outputs are high.
- R2: A read returns data with reg_rvalid_o high in the cycle after reg_rd_i. The channel is (address / 0x30) mod 2, and the offset is address mod 0x30. Offset 0x00 is control, 0x04 is status, 0x08 is the current-descriptor pointer and 0x10 is the tail-descriptor pointer. Every other offset reads zero.
- R3: Control bit 1 always reads 1, whatever value is written.
- R4: A control write with bit 0 set, made while the soft-reset flag is clear, clears halted (status bit 0) and idle (status bit 1). The run output follows control bit 0.
- R5: A tail-pointer write stores the value, clears idle, and raises that channel's tail_wr_o for exactly one cycle, in the cycle after the write.
- R6: Each completion pulse decrements the counter. When a completion takes the counter from 1 to 0, status bit 12 is set and the counter reloads from control bits 23:16.
- R7: A completion arrives while control bits 31:24 are nonzero loads the timer with that value. Each tick decrements a nonzero timer. When a tick takes the timer from 1 to 0, status bit 13 is set and the counter reloads from the threshold.
- R8: Status bits 31:24 read the live timer value and bits 23:16 read the live counter value.
- R9: irq_o of a channel is high exactly when (status bit 12 and control bit 12) or (status bit 13 and control bit 13).
- R10: Writing 1 to status bit 12 or bit 13 clears that bit. Writes to every other status bit have no effect.
- R11: A control write with bit 2 set is a soft reset. Control returns to threshold 1 with the flag (bit 2) set, status returns to halted, and the counter and timer return to 1 and 0. The next control read shows bit 2 as 1 and clears it. A control write made while the flag is set clears the flag but does not clear halted.
- R12: Any control write without bit 2 reloads the counter from the threshold in the written value.
- R13: An eng_idle_i pulse sets idle and an eng_halt_i pulse sets halted for that channel. A software clear in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the read |
| done_i | input | NUM_CH | Completion pulse per channel |
| tick_i | input | 1 | Prescaled timer tick, shared by all channels |
| eng_idle_i | input | NUM_CH | Engine reached the tail, sets idle |
| eng_halt_i | input | NUM_CH | Engine stopped, sets halted |
| run_o | output | NUM_CH | Control bit 0 per channel |
| idle_o | output | NUM_CH | Idle status per channel |
| halted_o | output | NUM_CH | Halted status per channel |
| irq_o | output | NUM_CH | Interrupt per channel |
| tail_wr_o | output | NUM_CH | One-cycle strobe after a tail-pointer write |
| cur_desc_o | output | NUM_CH*32 | Current-descriptor pointers, channel 0 in the low word |
| tail_desc_o | output | NUM_CH*32 | Tail-descriptor pointers, channel 0 in the low word |

## Verification
A counter that is off by one shows up as a status field that differs from the expected value on the very next read. It also moves the completion interrupt one pulse earlier or later, and irq_o shows that in the cycle after the deciding completion. A timer that misses a reload, or decrements when it should not, shows a wrong value in status bits 31:24 and a delay interrupt on the wrong tick. Wrong decode or a wrong soft-reset flag shows in the value returned one cycle after the read, or in a halted output that stays set or clears when it should not.

// File: rtl/dmac_pkg.sv
// Shared constants for the DMA channel control block.
// Assumes 32-bit registers. The field positions below are fixed by the
// software-visible layout.
package dmac_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned CNT_W      = 8;
    localparam int unsigned WIN_BYTES  = 48;

    // Word offsets (byte offset / 4) within a channel window
    localparam logic [3:0] WO_CTRL = 4'd0;
    localparam logic [3:0] WO_STAT = 4'd1;
    localparam logic [3:0] WO_CUR  = 4'd2;
    localparam logic [3:0] WO_TAIL = 4'd4;

    // Control bit positions
    localparam int unsigned CB_RUN   = 0;
    localparam int unsigned CB_TMODE = 1;
    localparam int unsigned CB_SRST  = 2;
    localparam int unsigned CB_EN_C  = 12;
    localparam int unsigned CB_EN_D  = 13;
    localparam int unsigned CB_THR   = 16;
    localparam int unsigned CB_DLY   = 24;

    // Status bit positions
    localparam int unsigned SB_IOC = 12;
    localparam int unsigned SB_DLY = 13;

    localparam logic [REG_W-1:0] CTRL_RESET = 32'h0001_0002;
endpackage

// File: rtl/dmac_coalesce.sv
// Interrupt coalescing for one channel: a completion down-counter with
// threshold reload, and a tick-driven delay timer that is armed again by
// each completion. The event outputs are single-cycle pulses that the
// channel register set captures.
// Assumes done_i and tick_i are single-cycle pulses.
module dmac_coalesce
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,        // soft reset of the channel
    input  logic             reload_i,     // control write: load reload_val_i
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic             done_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] tmr_o,
    output logic             ioc_evt_o,
    output logic             dly_evt_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, tmr_q;
    logic             rearm;

    // Event detection: counter reaching zero, timer expiring
    always_comb begin
        rearm     = done_i && (delay_i != '0);
        ioc_evt_o = done_i && (cnt_q == ONE) && !clr_i;
        dly_evt_o = tick_i && (tmr_q == ONE) && !rearm && !clr_i;
    end

    // Completion counter: reset or clear, explicit reload, event reload, decrement
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= ONE;
        else if (reload_i)
            cnt_q <= reload_val_i;
        else if (ioc_evt_o || dly_evt_o)
            cnt_q <= thresh_i;
        else if (done_i)
            cnt_q <= cnt_q - ONE;
    end

    // Delay timer: a completion rearms it, a tick decrements it while nonzero
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            tmr_q <= '0;
        else if (rearm)
            tmr_q <= delay_i;
        else if (tick_i && (tmr_q != '0))
            tmr_q <= tmr_q - ONE;
    end

    assign cnt_o = cnt_q;
    assign tmr_o = tmr_q;

    // R6: a completion on a counter of 1 leaves the threshold in the counter
    assert_cnt_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && cnt_q == ONE && !reload_i && !clr_i) |=> (cnt_q == $past(thresh_i)));

    // R7: a tick with no completion counts a nonzero timer down by one
    assert_tmr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !done_i && !clr_i && tmr_q != '0) |=> (tmr_q == $past(tmr_q) - ONE));

    // R7: a completion with a nonzero delay loads the timer with that delay
    assert_tmr_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && delay_i != '0 && !clr_i) |=> (tmr_q == $past(delay_i)));
endmodule

// File: rtl/dmac_channel.sv
// Register set of one DMA channel: control, status, the current and tail
// descriptor pointers, and the tail-write strobe. It holds one coalescing
// unit and forms the channel interrupt from status and enable bits.
// Assumes the strobes decoded by the parent are mutually exclusive.
module dmac_channel
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl_i,
    input  logic             wr_stat_i,
    input  logic             wr_cur_i,
    input  logic             wr_tail_i,
    input  logic             rd_ctrl_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             done_i,
    input  logic             tick_i,
    input  logic             eng_idle_i,
    input  logic             eng_halt_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] cur_o,
    output logic [REG_W-1:0] tail_o,
    output logic             tail_wr_o,
    output logic             run_o,
    output logic             idle_o,
    output logic             halted_o,
    output logic             irq_o
);
    logic [REG_W-1:0] ctrl_q, cur_q, tail_q;
    logic             halted_q, idle_q, ioc_q, dly_q, tail_wr_q;
    logic             soft_rst, start, reload;
    logic [CNT_W-1:0] cnt, tmr;
    logic             ioc_evt, dly_evt;

    // Strobes derived from the control write
    always_comb begin
        soft_rst = wr_ctrl_i && wdata_i[CB_SRST];
        reload   = wr_ctrl_i && !wdata_i[CB_SRST];
        start    = reload && wdata_i[CB_RUN] && !ctrl_q[CB_SRST];
    end

    // Control register: bit 1 forced to 1; the reset flag clears on the next control access
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (soft_rst)
            ctrl_q <= CTRL_RESET | (REG_W'(1) << CB_SRST);
        else if (wr_ctrl_i)
            ctrl_q <= wdata_i | (REG_W'(1) << CB_TMODE);
        else if (rd_ctrl_i)
            ctrl_q[CB_SRST] <= 1'b0;
    end

    // Status flags: software clears take priority over engine sets; event sets take priority over W1C
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            halted_q <= 1'b1;
            idle_q   <= 1'b0;
            ioc_q    <= 1'b0;
            dly_q    <= 1'b0;
        end else begin
            if (start)
                halted_q <= 1'b0;
            else if (eng_halt_i)
                halted_q <= 1'b1;
            if (start || wr_tail_i)
                idle_q <= 1'b0;
            else if (eng_idle_i)
                idle_q <= 1'b1;
            if (ioc_evt)
                ioc_q <= 1'b1;
            else if (wr_stat_i && wdata_i[SB_IOC])
                ioc_q <= 1'b0;
            if (dly_evt)
                dly_q <= 1'b1;
            else if (wr_stat_i && wdata_i[SB_DLY])
                dly_q <= 1'b0;
        end
    end

    // Descriptor pointers and the tail-write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            tail_q    <= '0;
            tail_wr_q <= 1'b0;
        end else begin
            if (wr_cur_i)
                cur_q <= wdata_i;
            if (wr_tail_i)
                tail_q <= wdata_i;
            tail_wr_q <= wr_tail_i;
        end
    end

    dmac_coalesce u_coal (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (soft_rst),
        .reload_i     (reload),
        .reload_val_i (wdata_i[CB_THR +: CNT_W]),
        .thresh_i     (ctrl_q[CB_THR +: CNT_W]),
        .delay_i      (ctrl_q[CB_DLY +: CNT_W]),
        .done_i       (done_i),
        .tick_i       (tick_i),
        .cnt_o        (cnt),
        .tmr_o        (tmr),
        .ioc_evt_o    (ioc_evt),
        .dly_evt_o    (dly_evt)
    );

    // Readback and outputs
    always_comb begin
        ctrl_o    = ctrl_q;
        stat_o    = {tmr, cnt, 2'b00, dly_q, ioc_q, 10'd0, idle_q, halted_q};
        cur_o     = cur_q;
        tail_o    = tail_q;
        tail_wr_o = tail_wr_q;
        run_o     = ctrl_q[CB_RUN];
        idle_o    = idle_q;
        halted_o  = halted_q;
        irq_o     = (ioc_q && ctrl_q[CB_EN_C]) || (dly_q && ctrl_q[CB_EN_D]);
    end

    // R6: a counter event is visible in status bit 12 in the next cycle
    assert_ioc_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ioc_evt && !soft_rst) |=> ioc_q);

    // R4: halted falls only after a run write made with the flag clear
    assert_halt_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted_q) |-> $past(wr_ctrl_i && wdata_i[CB_RUN] && !ctrl_q[CB_SRST]));

    // R11: a soft reset leaves the channel halted with the flag set
    assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (halted_q && ctrl_q[CB_SRST] && !irq_o));
endmodule

// File: rtl/dma_chan_ctrl.sv
// Top of the DMA channel control block. It decodes the register bus into
// per-channel strobes, instantiates one register set per channel, and
// returns read data with one cycle of latency.
// Assumes reg_wr_i and reg_rd_i are single-cycle strobes. A read and a
// write in the same cycle are both performed, and the read returns the
// values held before the write.
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_i,
    input  logic                    reg_rd_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic [REG_W-1:0]        reg_wdata_i,
    output logic [REG_W-1:0]        reg_rdata_o,
    output logic                    reg_rvalid_o,
    input  logic [NUM_CH-1:0]       done_i,
    input  logic                    tick_i,
    input  logic [NUM_CH-1:0]       eng_idle_i,
    input  logic [NUM_CH-1:0]       eng_halt_i,
    output logic [NUM_CH-1:0]       run_o,
    output logic [NUM_CH-1:0]       idle_o,
    output logic [NUM_CH-1:0]       halted_o,
    output logic [NUM_CH-1:0]       irq_o,
    output logic [NUM_CH-1:0]       tail_wr_o,
    output logic [NUM_CH*REG_W-1:0] cur_desc_o,
    output logic [NUM_CH*REG_W-1:0] tail_desc_o
);
    int          ch_sel;
    logic [3:0]  word;
    logic [REG_W-1:0] ctrl_a [NUM_CH];
    logic [REG_W-1:0] stat_a [NUM_CH];
    logic [REG_W-1:0] cur_a  [NUM_CH];
    logic [REG_W-1:0] tail_a [NUM_CH];
    logic [REG_W-1:0] rdata_d, rdata_q;
    logic             rvalid_q;

    // Address split: channel from the window number, word from the offset
    always_comb begin
        int a;
        a      = int'(reg_addr_i);
        ch_sel = (a / int'(WIN_BYTES)) % int'(NUM_CH);
        word   = 4'((a % int'(WIN_BYTES)) >> 2);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = (ch_sel == i);

        dmac_channel u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctrl_i  (reg_wr_i && sel && word == WO_CTRL),
            .wr_stat_i  (reg_wr_i && sel && word == WO_STAT),
            .wr_cur_i   (reg_wr_i && sel && word == WO_CUR),
            .wr_tail_i  (reg_wr_i && sel && word == WO_TAIL),
            .rd_ctrl_i  (reg_rd_i && sel && word == WO_CTRL),
            .wdata_i    (reg_wdata_i),
            .done_i     (done_i[i]),
            .tick_i     (tick_i),
            .eng_idle_i (eng_idle_i[i]),
            .eng_halt_i (eng_halt_i[i]),
            .ctrl_o     (ctrl_a[i]),
            .stat_o     (stat_a[i]),
            .cur_o      (cur_a[i]),
            .tail_o     (tail_a[i]),
            .tail_wr_o  (tail_wr_o[i]),
            .run_o      (run_o[i]),
            .idle_o     (idle_o[i]),
            .halted_o   (halted_o[i]),
            .irq_o      (irq_o[i])
        );

        assign cur_desc_o[i*REG_W +: REG_W]  = cur_a[i];
        assign tail_desc_o[i*REG_W +: REG_W] = tail_a[i];

        // R5: the tail strobe only ever follows a bus write
        assert_tail_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tail_wr_o[i] |-> $past(reg_wr_i));
    end

    // Read mux over the selected channel; unmapped offsets give zero
    always_comb begin
        rdata_d = '0;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (ch_sel == i) begin
                case (word)
                    WO_CTRL: rdata_d = ctrl_a[i];
                    WO_STAT: rdata_d = stat_a[i];
                    WO_CUR:  rdata_d = cur_a[i];
                    WO_TAIL: rdata_d = tail_a[i];
                    default: rdata_d = '0;
                endcase
            end
        end
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= reg_rd_i;
            if (reg_rd_i)
                rdata_q <= rdata_d;
        end
    end

    assign reg_rdata_o  = rdata_q;
    assign reg_rvalid_o = rvalid_q;

    // R2: read data is valid exactly one cycle after a read strobe
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid_o |-> $past(reg_rd_i));
endmodule

// File: tb/tb_dma_chan_ctrl.sv
// Directed bench for dma_chan_ctrl: one task per scenario, each task checks its own results.
module tb_dma_chan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [1:0]  done = '0, eng_idle = '0, eng_halt = '0;
    logic        tick = 1'b0;
    logic [1:0]  run, idle, halted, irq, tail_wr;
    logic [63:0] cur_desc, tail_desc;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    dma_chan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .reg_rvalid_o(reg_rvalid), .done_i(done), .tick_i(tick),
        .eng_idle_i(eng_idle), .eng_halt_i(eng_halt), .run_o(run), .idle_o(idle),
        .halted_o(halted), .irq_o(irq), .tail_wr_o(tail_wr),
        .cur_desc_o(cur_desc), .tail_desc_o(tail_desc)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic brd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R2 rvalid", {63'd0, reg_rvalid}, 64'd1);
        d = reg_rdata;
    endtask

    task automatic rchk(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        brd(a, d);
        check(req, {32'd0, d}, {32'd0, exp});
    endtask

    task automatic pulse_done(input int ch);
        @(negedge clk); done[ch] = 1'b1;
        @(negedge clk); done = '0;
    endtask

    task automatic pulse_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1 irq", {62'd0, irq}, 64'd0);
        check("R1 run", {62'd0, run}, 64'd0);
        check("R1 halted", {62'd0, halted}, 64'd3);
        rchk("R1 ch0 status", 7'h04, 32'h0001_0001);
        rchk("R1 ch0 control", 7'h00, 32'h0001_0002);
        rchk("R1 ch1 status", 7'h34, 32'h0001_0001);
    endtask

    task automatic t_map;
        bwr(7'h08, 32'hA000_0010);
        bwr(7'h38, 32'hB000_0020);
        bwr(7'h40, 32'hB000_0F00);
        rchk("R2 ch0 cur", 7'h08, 32'hA000_0010);
        rchk("R2 ch1 cur", 7'h38, 32'hB000_0020);
        rchk("R2 ch1 tail", 7'h40, 32'hB000_0F00);
        rchk("R2 unmapped 0x0C", 7'h0C, 32'h0);
        rchk("R2 unmapped 0x2C", 7'h2C, 32'h0);
        rchk("R2 alias 0x68 to ch0", 7'h68, 32'hA000_0010);
        check("R2 cur port", cur_desc, {32'hB000_0020, 32'hA000_0010});
        check("R2 tail port", tail_desc[63:32], 64'hB000_0F00);
    endtask

    task automatic t_tmode;
        bwr(7'h00, 32'h0000_0000);
        rchk("R3 bit1 stays set", 7'h00, 32'h0000_0002);
        rchk("R12 threshold 0 loaded", 7'h04, 32'h0000_0001);
    endtask

    task automatic t_run;
        bwr(7'h00, 32'h0003_0001);
        check("R4 halted cleared", {63'd0, halted[0]}, 64'd0);
        check("R4 run out", {63'd0, run[0]}, 64'd1);
        rchk("R4 status", 7'h04, 32'h0003_0000);
        @(negedge clk); eng_idle = 2'b01;
        @(negedge clk); eng_idle = '0;
        check("R13 idle set", {62'd0, idle}, 64'd1);
        rchk("R13 idle bit", 7'h04, 32'h0003_0002);
    endtask

    task automatic t_tail;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'h10; reg_wdata = 32'h1234_5670;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R5 strobe high", {62'd0, tail_wr}, 64'd1);
        check("R5 idle cleared", {62'd0, idle}, 64'd0);
        @(negedge clk);
        check("R5 strobe one cycle", {62'd0, tail_wr}, 64'd0);
        rchk("R5 tail stored", 7'h10, 32'h1234_5670);
        @(negedge clk); eng_halt = 2'b01;
        @(negedge clk); eng_halt = '0;
        check("R13 halted set", {63'd0, halted[0]}, 64'd1);
    endtask

    task automatic t_count;
        bwr(7'h30, 32'h0003_1001);
        pulse_done(1);
        pulse_done(1);
        rchk("R8 counter after 2", 7'h34, 32'h0001_0000);
        check("R6 no irq yet", {63'd0, irq[1]}, 64'd0);
        pulse_done(1);
        check("R6 irq at zero", {63'd0, irq[1]}, 64'd1);
        rchk("R6 bit12 and reload", 7'h34, 32'h0003_1000);
    endtask

    task automatic t_w1c;
        bwr(7'h34, 32'h0000_0003);
        rchk("R10 bit12 kept on zero", 7'h34, 32'h0003_1000);
        bwr(7'h34, 32'h0000_1003);
        rchk("R10 bit12 cleared, others unchanged", 7'h34, 32'h0003_0000);
        check("R10 irq low", {63'd0, irq[1]}, 64'd0);
    endtask

    task automatic t_delay;
        bwr(7'h00, 32'h0502_2001);
        pulse_done(0);
        rchk("R8 timer and counter", 7'h04, 32'h0501_0000);
        pulse_tick(4);
        rchk("R7 timer counted down", 7'h04, 32'h0101_0000);
        check("R7 no irq before expiry", {63'd0, irq[0]}, 64'd0);
        pulse_tick(1);
        check("R7 irq on expiry", {63'd0, irq[0]}, 64'd1);
        rchk("R7 bit13 and reload", 7'h04, 32'h0002_2000);
        bwr(7'h00, 32'h0502_0001);
        check("R9 masked", {63'd0, irq[0]}, 64'd0);
        rchk("R9 bit13 still pending", 7'h04, 32'h0002_2000);
        bwr(7'h00, 32'h0502_2001);
        check("R9 unmasked", {63'd0, irq[0]}, 64'd1);
        bwr(7'h04, 32'h0000_2000);
        check("R10 bit13 cleared", {63'd0, irq[0]}, 64'd0);
        pulse_done(0);
        pulse_tick(2);
        pulse_done(0);
        rchk("R7 rearm on completion", 7'h04, 32'h0502_1000);
        check("R9 bit12 not enabled", {63'd0, irq[0]}, 64'd0);
    endtask

    task automatic t_reload;
        bwr(7'h30, 32'h0003_0001);
        pulse_done(1);
        rchk("R12 counter 2", 7'h34, 32'h0002_0000);
        bwr(7'h30, 32'h0007_0001);
        rchk("R12 reload on write", 7'h34, 32'h0007_0000);
    endtask

    task automatic t_soft;
        bwr(7'h30, 32'h0000_0004);
        check("R11 halted", {63'd0, halted[1]}, 64'd1);
        rchk("R11 status", 7'h34, 32'h0001_0001);
        bwr(7'h30, 32'h0000_0001);
        check("R11 run ignored while flag set", {63'd0, halted[1]}, 64'd1);
        rchk("R11 flag cleared by write", 7'h30, 32'h0000_0003);
        bwr(7'h30, 32'h0000_0001);
        check("R11 run after flag", {63'd0, halted[1]}, 64'd0);
        bwr(7'h30, 32'h0000_0004);
        rchk("R11 flag reads once", 7'h30, 32'h0001_0006);
        rchk("R11 flag then clear", 7'h30, 32'h0001_0002);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_tmode();
        t_run();
        t_tail();
        t_count();
        t_w1c();
        t_delay();
        t_reload();
        t_soft();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule